// File: doc/BRIEF.md
# Memory-backed FIFO burst writer

This block is the write half of a FIFO whose bulk storage lives in external memory reached over AXI4. A small local FIFO, owned by the surrounding design, collects incoming words. The block keeps its own count of the words in that FIFO that no burst has yet claimed. Whenever a full burst's worth is waiting and the external memory has room, it issues one fixed-length incrementing write burst and streams the words straight from the head of the local FIFO onto the write data channel.

Every burst has the same power-of-two length, so each burst starts on a burst-sized address boundary and can never cross a 4 kB page. The external memory is treated as a ring, and its free room is tracked in whole bursts. A read-side engine returns a burst's room when it has consumed it. The burst's words and its memory slot are claimed in the cycle after the issue decision, before the address handshake completes. This means a stalled AWREADY never delays the bookkeeping. Each OKAY write response adds one to a committed-burst count that the read side watches. An error response stops all further bursts until the next hardware reset.

Top module: `vfifo_burst_writer`

## Requirements
- R1: Every write burst is incrementing (`m_awburst` = 2'b01), has `m_awlen` = 2^LGMAXBURST - 1, has `m_awsize` = log2 of the bus width in bytes, and has every `m_wstrb` bit set.
- R2: A burst is issued only when the words pushed but not yet claimed by an earlier burst number at least 2^LGMAXBURST. Fewer waiting words never produce an address request.
- R3: From idle, the push that completes a burst makes `m_awvalid` and `m_wvalid` rise together two clock edges later. `m_awvalid` then stays high, with `m_awaddr` unchanged, until `m_awready` is seen.
- R4: Each W handshake carries `in_head` and pulses `in_pop`. `m_wlast` is high exactly on beat 2^LGMAXBURST - 1 of each burst, counting from 0.
- R5: A new burst waits until the previous address has been accepted and its last data beat has been handshaken. With data and memory room available and both ready signals held high, the first beat of the next burst follows the last beat of the previous one with no idle cycle.
- R6: After reset, the first burst address is 0. Each accepted address advances the next by 2^LGMAXBURST times the bus width in bytes, modulo 2^ADDR_W. The address bits below that burst size are always zero.
- R7: The memory holds 2^(ADDR_W - LGMAXBURST - log2 bytes) bursts, and all of them are free after reset. Each issued burst takes one. Each `mem_release` pulse returns one. No burst is issued while none is free.
- R8: While `soft_reset` is high, no new burst is issued. A `soft_reset` cycle with no stalled address request sets the next burst address to 0.
- R9: `m_bready` is always high. Each B handshake with `m_bresp` = 2'b00 raises `committed` by one, visible from the next cycle.
- R10: A B handshake with `m_bresp[1]` = 1 stops every later burst until `rst_n` is pulsed low. A burst already in flight completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Holds off new bursts and clears the address when no request is stalled |
| in_push | input | 1 | One word entered the local FIFO this cycle |
| in_head | input | DATA_W | Word at the head of the local FIFO |
| in_pop | output | 1 | Head word taken onto the W channel this cycle |
| mem_release | input | 1 | Read side has freed one burst of memory |
| m_awaddr | output | ADDR_W | Burst address |
| m_awlen | output | 8 | Beats per burst minus one |
| m_awsize | output | 3 | Log2 of bytes per beat |
| m_awburst | output | 2 | Burst type, incrementing |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address accepted |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of the burst |
| m_wvalid | output | 1 | Data valid |
| m_wready | input | 1 | Data accepted |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Response valid |
| m_bready | output | 1 | Response accepted, always high |
| committed | output | CNT_W | Bursts written with OKAY, wraps |

## Verification
A burst becomes due two edges after the push that completes it. The bench pins that down exactly: it samples `m_awvalid` low one negative edge after the push and high on the following one. W beats and AW requests are scored in the same negative-edge pass that chooses the ready levels for the coming edge, so every handshake is judged on the values the edge will capture. The `committed` count is compared one cycle after the response that changes it. Blocking conditions, namely a short data count, soft reset, a full memory and a halt after an error, are judged over windows of tens to hundreds of cycles, and the address count must not move during them.

// File: rtl/vfifo_burst_writer.sv
module vfifo_burst_writer #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LGMAXBURST = 4,
  parameter int LGFIFO     = 8,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_reset,
  input  logic                  in_push,
  input  logic [DATA_W-1:0]     in_head,
  output logic                  in_pop,
  input  logic                  mem_release,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic [CNT_W-1:0]      committed
);
  localparam int BYTES   = DATA_W / 8;
  localparam int ADDRLSB = $clog2(BYTES);
  localparam int BURST   = 1 << LGMAXBURST;
  localparam int LOW     = LGMAXBURST + ADDRLSB;
  localparam int MEMW    = ADDR_W - LOW;

  logic [LGFIFO:0]       avail;
  logic [MEMW:0]         free_bursts;
  logic [MEMW-1:0]       addr_hi;
  logic [LGMAXBURST-1:0] beat;
  logic                  phantom, halted, awvalid_q, wvalid_q;
  logic [CNT_W-1:0]      commit_q;

  wire bad_b     = m_bvalid && m_bresp[1];
  wire aw_stall  = awvalid_q && !m_awready;
  wire last_beat = beat == LGMAXBURST'(BURST - 1);
  wire w_busy    = wvalid_q && !(m_wready && last_beat);
  wire enough    = |avail[LGFIFO:LGMAXBURST];
  wire mem_full  = free_bursts == '0;
  wire start     = !halted && !bad_b && !soft_reset && enough && !mem_full
                   && !phantom && !aw_stall && !w_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) avail <= '0;
    else avail <= avail + (LGFIFO+1)'(in_push)
                  - (phantom ? (LGFIFO+1)'(BURST) : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) free_bursts <= {1'b1, {MEMW{1'b0}}};
    else free_bursts <= free_bursts - (MEMW+1)'(phantom) + (MEMW+1)'(mem_release);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_hi <= '0;
    else if (soft_reset && !aw_stall) addr_hi <= '0;
    else if (awvalid_q && m_awready) addr_hi <= addr_hi + MEMW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      awvalid_q <= 1'b0;
      phantom   <= 1'b0;
    end else begin
      phantom <= start;
      if (start) awvalid_q <= 1'b1;
      else if (m_awready) awvalid_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wvalid_q <= 1'b0;
      beat     <= '0;
    end else if (start) begin
      wvalid_q <= 1'b1;
      beat     <= '0;
    end else if (wvalid_q && m_wready) begin
      if (last_beat) wvalid_q <= 1'b0;
      beat <= beat + LGMAXBURST'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      halted   <= 1'b0;
      commit_q <= '0;
    end else if (m_bvalid) begin
      if (bad_b) halted <= 1'b1;
      if (m_bresp == 2'b00) commit_q <= commit_q + CNT_W'(1);
    end

  assign m_awaddr  = {addr_hi, {LOW{1'b0}}};
  assign m_awlen   = 8'(BURST - 1);
  assign m_awsize  = 3'(ADDRLSB);
  assign m_awburst = 2'b01;
  assign m_awvalid = awvalid_q;
  assign m_wdata   = in_head;
  assign m_wstrb   = '1;
  assign m_wvalid  = wvalid_q;
  assign m_wlast   = wvalid_q && last_beat;
  assign in_pop    = wvalid_q && m_wready;
  assign m_bready  = 1'b1;
  assign committed = commit_q;
endmodule

// File: rtl/vfifo_burst_writer_chk.sv
module vfifo_burst_writer_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LGMAXBURST = 4,
  parameter int LGFIFO     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_reset,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic              bvalid,
  input logic [1:0]        bresp,
  input logic              phantom,
  input logic [LGFIFO:0]   avail,
  input logic [ADDR_W-LGMAXBURST-$clog2(DATA_W/8):0] free_bursts
);
  localparam int BURST = 1 << LGMAXBURST;
  localparam int STEP  = BURST * (DATA_W / 8);

  logic                  err_seen;
  logic [LGMAXBURST-1:0] bc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_seen <= 1'b0;
      bc       <= '0;
    end else begin
      if (bvalid && bresp[1]) err_seen <= 1'b1;
      if (wvalid && wready) bc <= bc + LGMAXBURST'(1);
    end

  // R2
  claim_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phantom |-> avail >= (LGFIFO+1)'(BURST));
  // R5
  phantom_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phantom |=> !phantom);
  // R3
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  // R3
  aw_w_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> wvalid && ($past(!wvalid) || $past(wready && wlast)));
  // R4
  wlast_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wlast == (bc == LGMAXBURST'(BURST - 1))));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready && !soft_reset |=> awaddr == ADDR_W'($past(awaddr) + ADDR_W'(STEP)));
  // R7
  mem_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_bursts == '0 |=> !$rose(awvalid));
  // R8
  soft_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !$rose(awvalid));
  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |-> !$rose(awvalid));
endmodule

bind vfifo_burst_writer vfifo_burst_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LGMAXBURST(LGMAXBURST), .LGFIFO(LGFIFO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset),
  .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
  .wvalid(m_wvalid), .wready(m_wready), .wlast(m_wlast),
  .bvalid(m_bvalid), .bresp(m_bresp),
  .phantom(phantom), .avail(avail), .free_bursts(free_bursts)
);

// File: tb/vfifo_burst_writer_test.sv
module vfifo_burst_writer_test;
  localparam int AW = 8, DW = 32, LGB = 2, LGF = 4, CW = 8;
  localparam int BURST = 1 << LGB;
  localparam int STEP = BURST * DW / 8;
  localparam int SLOTS = 1 << (AW - LGB - 2);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, soft_reset = 1'b0, in_push = 1'b0, mem_release = 1'b0;
  logic [DW-1:0] in_head;
  logic in_pop, m_awvalid, m_awready = 1'b0, m_wlast, m_wvalid, m_wready = 1'b0;
  logic [AW-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst, m_bresp = 2'b00;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic m_bvalid = 1'b0, m_bready;
  logic [CW-1:0] committed;

  vfifo_burst_writer #(.ADDR_W(AW), .DATA_W(DW), .LGMAXBURST(LGB), .LGFIFO(LGF), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .in_push(in_push), .in_head(in_head),
    .in_pop(in_pop), .mem_release(mem_release), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
    .m_awsize(m_awsize), .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .committed(committed));

  int errs = 0, checks = 0;
  logic [DW-1:0] fifo_mem [0:15];
  int wp = 0, rp = 0, bc = 0, b_pend = 0, exp_addr = 0, exp_commit = 0, released = 0;
  int aw_count = 0, w_count = 0, cyc = 0, push_budget = 0, release_budget = 0;
  int push_pct = 100, ar_pct = 100, wr_pct = 100, b_pct = 100;
  bit auto_release = 1'b1, inject_err = 1'b0;
  int w_cyc [0:1023];

  assign in_head = fifo_mem[rp % 16];

  function automatic logic [DW-1:0] word(input int i);
    return 32'hC0DE_0000 + DW'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_awready = 0; m_wready = 0; m_bvalid = 0; in_push = 0; mem_release = 0;
    end else begin
      cyc++;
      chk(committed == CW'(exp_commit), "R9", "committed", committed, exp_commit);
      m_awready = $urandom_range(99) < ar_pct;
      m_wready  = $urandom_range(99) < wr_pct;
      m_bvalid  = b_pend > 0 && $urandom_range(99) < b_pct;
      m_bresp   = 2'b00;
      if (m_bvalid && inject_err) begin m_bresp = 2'b10; inject_err = 0; end
      in_push = push_budget > 0 && (wp - rp) < 16 && $urandom_range(99) < push_pct;
      if (in_push) begin fifo_mem[wp % 16] = word(wp); wp++; push_budget--; end
      mem_release = released < exp_commit && (auto_release || release_budget > 0);
      if (mem_release) begin released++; if (release_budget > 0) release_budget--; end
      if (m_awvalid && m_awready) begin
        chk(m_awaddr == AW'(exp_addr), "R6", "awaddr", m_awaddr, exp_addr);
        chk(m_awlen == 8'(BURST-1) && m_awsize == 3'd2 && m_awburst == 2'b01, "R1", "aw fields",
            {m_awlen, m_awsize, m_awburst}, {8'(BURST-1), 3'd2, 2'b01});
        aw_count++;
      end
      if (m_wvalid && m_wready) begin
        chk(m_wdata == word(rp), "R4", "wdata", m_wdata, word(rp));
        chk(m_wlast == (bc == BURST-1), "R4", "wlast", m_wlast, bc == BURST-1);
        chk(m_wstrb == '1, "R1", "wstrb", m_wstrb, 15);
        w_cyc[w_count % 1024] = cyc; w_count++;
        if (bc == BURST-1) b_pend++;
        rp++; bc = (bc + 1) % BURST;
      end
      if (m_bvalid) begin
        chk(m_bready == 1'b1, "R9", "bready", m_bready, 1);
        b_pend--;
        if (m_bresp == 2'b00) exp_commit++;
      end
      if (m_awvalid && m_awready && !soft_reset) exp_addr = (exp_addr + STEP) % (1 << AW);
      if (soft_reset && !(m_awvalid && !m_awready)) exp_addr = 0;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic drain;
    for (int i = 0; i < 3000; i++) begin
      if (push_budget == 0 && wp == rp && b_pend == 0 && !m_awvalid && !m_wvalid) break;
      step(1);
    end
    step(3);
  endtask

  initial begin
    automatic int base, cap, w0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(!m_awvalid && !m_wvalid && committed == 0, "R3", "reset outputs idle", {m_awvalid, m_wvalid}, 0);
    chk(m_awaddr == 0, "R6", "reset address", m_awaddr, 0);

    push_budget = 3; step(15);
    chk(aw_count == 0 && !m_awvalid, "R2", "three words issue nothing", aw_count, 0);
    push_budget = 1;
    step(1);
    step(1); chk(!m_awvalid, "R3", "awvalid one edge after push", m_awvalid, 0);
    step(1); chk(m_awvalid && m_wvalid, "R3", "awvalid and wvalid two edges after push", {m_awvalid, m_wvalid}, 3);
    drain;
    chk(exp_commit == 1 && rp == 4, "R9", "one burst committed", exp_commit, 1);

    soft_reset = 1'b1; push_budget = 8; step(40);
    chk(aw_count == 1, "R8", "no burst under soft reset", aw_count, 1);
    chk(m_awaddr == 0, "R8", "soft reset clears address", m_awaddr, 0);
    w0 = w_count;
    soft_reset = 1'b0; drain;
    chk(aw_count == 3, "R2", "eight words give two bursts", aw_count, 3);
    chk(w_cyc[(w0 + 7) % 1024] - w_cyc[w0 % 1024] == 7, "R5", "back-to-back beats",
        w_cyc[(w0 + 7) % 1024] - w_cyc[w0 % 1024], 7);

    step(5);
    auto_release = 1'b0;
    cap = SLOTS - (aw_count - released);
    base = aw_count;
    push_budget = cap * BURST + BURST; step(400);
    chk(aw_count - base == cap, "R7", "bursts stop at full memory", aw_count - base, cap);
    release_budget = 1; step(60);
    chk(aw_count - base == cap + 1, "R7", "release frees one burst", aw_count - base, cap + 1);
    auto_release = 1'b1; drain;

    for (int d = 0; d < 4; d++) begin
      automatic int pct = 100 - d * 28;
      ar_pct = pct; wr_pct = 115 - pct; b_pct = pct; push_pct = 30 + d * 20;
      base = aw_count;
      push_budget = 200; drain;
      chk(aw_count - base == 50, "R2", "sweep burst count", aw_count - base, 50);
      chk(rp == wp, "R4", "sweep all words sent", rp, wp);
      chk(committed == CW'(exp_commit), "R9", "sweep committed", committed, exp_commit);
    end
    ar_pct = 100; wr_pct = 100; b_pct = 100; push_pct = 100;

    inject_err = 1'b1; push_budget = 4; step(30);
    base = aw_count; cap = exp_commit;
    push_budget = 8; step(80);
    chk(aw_count == base && !m_awvalid, "R10", "halted after error", aw_count, base);
    chk(exp_commit == cap, "R10", "error not committed", exp_commit, cap);

    rst_n = 1'b0; step(2);
    push_budget = 0; rp = wp; bc = 0; b_pend = 0; exp_addr = 0; exp_commit = 0; released = 0;
    rst_n = 1'b1; step(1);
    base = aw_count;
    push_budget = 4; drain;
    chk(aw_count - base == 1 && committed == 1, "R10", "recovery after reset", aw_count - base, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule